// File: doc/BRIEF.md
# Programmable Strobe Divider with Lock Indication

This block divides a reference clock by a software-chosen ratio N. It does not generate a new clock. It emits a one-cycle enable strobe every N reference cycles, so everything downstream stays in the reference clock domain. Software controls it through one 32-bit control word on a simple synchronous write port. The read port is combinational.

A newly written ratio is only staged. The running division changes only when software writes the word with the load command bit set. The load restarts the counter and drops a lock flag. The flag returns once one full output period at the new ratio has completed.

A separate command bit starts a fixed-length reset pulse for the downstream domain. An elaboration parameter selects which bit of the read word carries the lock flag.

Top module: `strobe_divider`

## Requirements
- R1: After synchronous reset the strobe is gated off, the staged and active ratio is 1, the lock flag is 1, and the domain reset output is 0. With default lock placement the read word is 32'h8000_0010.
- R2: The read word has the following layout:
  - bit 0 is the enable;
  - bits 4 upward hold the staged ratio field, DIV_W bits wide;
  - the lock flag sits at its bit position.

  Every other bit reads 0, including written bits above the field.
- R3: While enabled with an active ratio N of 1 or more, `tick_o` is high for exactly one cycle in every N cycles.
- R4: A ratio field value of 0 acts as a ratio of 1, so the strobe is high on every cycle.
- R5: Writing the ratio field without the load bit (bit 2) leaves the running period unchanged, although the new field value reads back.
- R6: A write with the load bit set takes the ratio from that same write. The lock flag reads 0 from the first cycle after the write edge. It reads 1 again exactly N cycles after that edge, which is within 4×N cycles.
- R7: After a load, the counter restarts from zero: the first strobe comes in the N-th cycle after the write edge, and strobes then follow every N cycles.
- R8: While the enable is 0, `tick_o` stays 0. The counter and the lock sequencing still run.
- R9: A write with the reset request bit (bit 1) set drives `domain_rst_o` high for exactly RST_CYCLES cycles, starting in the cycle after the write edge.
- R10: The load and reset request bits are self-clearing and always read back as 0.
- R11: With LOCK_AT_ALT set, the lock flag appears at bit 27 instead of bit 31, and bit 31 reads 0.
- R12: A single write can clear the enable, set a new field value and issue a load together. The strobe stays off and the lock still re-acquires after N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Write strobe for the control word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational from state) |
| tick_o | output | 1 | One-cycle enable strobe every N cycles |
| domain_rst_o | output | 1 | Reset pulse for the downstream domain |

## Verification
The write edge is cycle 0. After that edge the lock flag reads 0 at once. It reads 1 from the N-th cycle on, and the first strobe comes in cycle N-1. The domain reset output is high from cycle 0 through cycle RST_CYCLES-1.

Inputs change on the falling edge, and every output is sampled on the falling edge after the rising edge it depends on. Each cycle of the walk from a load is therefore compared at a known index j, with the strobe expected exactly when j mod N equals N-1. For the staged-field case, the check counts strobes over a window that is a multiple of both the old and the new period, so the result does not depend on the counter's phase.

// File: rtl/strobe_div_pkg.sv
package strobe_div_pkg;
   localparam int CTRL_W      = 32;
   localparam int EN_POS      = 0;
   localparam int RSTREQ_POS  = 1;
   localparam int LOAD_POS    = 2;
   localparam int FIELD_LSB   = 4;
   localparam int LOCK_STD    = 31;
   localparam int LOCK_ALT    = 27;

   function automatic int lock_pos(input bit alt);
      return alt ? LOCK_ALT : LOCK_STD;
   endfunction
endpackage

// File: rtl/strobe_div_regs.sv
module strobe_div_regs
   import strobe_div_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter bit LOCK_AT_ALT = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              bus_wr_i,
   input  logic [CTRL_W-1:0] bus_wdata_i,
   input  logic              locked_i,
   output logic [CTRL_W-1:0] bus_rdata_o,
   output logic              en_o,
   output logic [DIV_W-1:0]  div_act_o,
   output logic              load_o,
   output logic              rstreq_o
);
   localparam int FIELD_TOP = FIELD_LSB + DIV_W;

   logic [DIV_W-1:0]  field_q;
   logic [DIV_W-1:0]  wr_field;
   logic [CTRL_W-1:0] lock_vec;
   logic              unused_wbits;

   assign wr_field     = bus_wdata_i[FIELD_LSB +: DIV_W];
   assign load_o       = bus_wr_i & bus_wdata_i[LOAD_POS];
   assign rstreq_o     = bus_wr_i & bus_wdata_i[RSTREQ_POS];
   assign unused_wbits = ^{bus_wdata_i[3], bus_wdata_i[CTRL_W-1:FIELD_TOP]};

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         en_o      <= 1'b0;
         field_q   <= DIV_W'(1);
         div_act_o <= DIV_W'(1);
      end else if (bus_wr_i) begin
         en_o    <= bus_wdata_i[EN_POS];
         field_q <= wr_field;
         if (bus_wdata_i[LOAD_POS])
            div_act_o <= wr_field;
      end
   end

   generate
      if (LOCK_AT_ALT) begin : g_lock_alt
         assign lock_vec = CTRL_W'(locked_i) << LOCK_ALT;
      end else begin : g_lock_std
         assign lock_vec = CTRL_W'(locked_i) << LOCK_STD;
      end
   endgenerate

   always_comb begin
      bus_rdata_o                        = lock_vec;
      bus_rdata_o[EN_POS]                = en_o;
      bus_rdata_o[FIELD_LSB +: DIV_W]    = field_q;
   end

   // R5: the active ratio moves only on a load write
   p_stage_only_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      !load_o |=> $stable(div_act_o));
   // R6: a load takes the ratio of the same write
   p_load_takes_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      load_o |=> div_act_o == $past(wr_field));
endmodule

// File: rtl/strobe_div_counter.sv
module strobe_div_counter #(
   parameter int DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             load_i,
   output logic             tick_o,
   output logic             locked_o
);
   logic [DIV_W-1:0] eff;
   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   assign eff    = (div_i == '0) ? DIV_W'(1) : div_i;
   assign wrap   = (cnt_q == eff - DIV_W'(1));
   assign tick_o = en_i & wrap;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q    <= '0;
         locked_o <= 1'b1;
      end else if (load_i) begin
         cnt_q    <= '0;
         locked_o <= 1'b0;
      end else begin
         cnt_q <= wrap ? '0 : cnt_q + DIV_W'(1);
         if (wrap)
            locked_o <= 1'b1;
      end
   end

   // R3: counter never passes the active ratio
   p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q < eff);
   // R3: no back-to-back strobes unless the ratio is 1
   p_tick_spacing_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick_o && !load_i && eff != DIV_W'(1)) |=> !tick_o);
   // R6: lock drops right after a load
   p_lock_drop_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      load_i |=> !locked_o);
   // R6: lock returns only at the end of a full period
   p_lock_rise_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(locked_o) |-> $past(wrap) && !$past(load_i));
endmodule

// File: rtl/strobe_div_rstpulse.sv
module strobe_div_rstpulse #(
   parameter int RST_CYCLES = 125
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic req_i,
   output logic pulse_o
);
   localparam int CW = $clog2(RST_CYCLES + 1);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)
         left_q <= '0;
      else if (req_i)
         left_q <= CW'(RST_CYCLES);
      else if (left_q != '0)
         left_q <= left_q - CW'(1);
   end

   assign pulse_o = (left_q != '0);

   // R9: a request raises the pulse in the next cycle
   p_req_starts_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      req_i |=> pulse_o);
   // R9: the pulse cannot end while more than one cycle remains
   p_pulse_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (pulse_o && left_q > CW'(1)) |=> pulse_o);
endmodule

// File: rtl/strobe_divider.sv
module strobe_divider
   import strobe_div_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter bit LOCK_AT_ALT = 1'b0,
   parameter int RST_CYCLES  = 125
) (
   input  logic        clk_i,
   input  logic        rst_i,
   input  logic        bus_wr_i,
   input  logic [31:0] bus_wdata_i,
   output logic [31:0] bus_rdata_o,
   output logic        tick_o,
   output logic        domain_rst_o
);
   generate
      if (DIV_W < 1 || FIELD_LSB + DIV_W > LOCK_ALT) begin : g_bad_width
         $error("DIV_W must fit between bit 4 and the lock bit");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("RST_CYCLES must be at least 1");
      end
   endgenerate

   logic             en;
   logic [DIV_W-1:0] div_act;
   logic             load;
   logic             rstreq;
   logic             locked;

   strobe_div_regs #(.DIV_W(DIV_W), .LOCK_AT_ALT(LOCK_AT_ALT)) u_regs (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .bus_wr_i    (bus_wr_i),
      .bus_wdata_i (bus_wdata_i),
      .locked_i    (locked),
      .bus_rdata_o (bus_rdata_o),
      .en_o        (en),
      .div_act_o   (div_act),
      .load_o      (load),
      .rstreq_o    (rstreq)
   );

   strobe_div_counter #(.DIV_W(DIV_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .en_i     (en),
      .div_i    (div_act),
      .load_i   (load),
      .tick_o   (tick_o),
      .locked_o (locked)
   );

   strobe_div_rstpulse #(.RST_CYCLES(RST_CYCLES)) u_rst (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .req_i   (rstreq),
      .pulse_o (domain_rst_o)
   );

   // R8: a disabled block never strobes
   p_gate_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      !bus_rdata_o[EN_POS] |-> !tick_o);
   // R10: command bits never read back as set
   p_selfclear_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      bus_rdata_o[LOAD_POS] == 1'b0 && bus_rdata_o[RSTREQ_POS] == 1'b0);
endmodule

// File: tb/strobe_divider_test.sv
module strobe_divider_test;
   localparam int BENCH_RST = 20;
   localparam int NVEC = 7;
   localparam int VEC_FIELD [NVEC] = '{0, 1, 2, 3, 5, 9, 255};
   localparam int VEC_N     [NVEC] = '{1, 1, 2, 3, 5, 9, 255};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, rdata_alt;
   logic        tick, tick_alt, drst, drst_alt;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   strobe_divider #(.DIV_W(8), .LOCK_AT_ALT(1'b0), .RST_CYCLES(BENCH_RST)) uut (
      .clk_i(clk), .rst_i(rst), .bus_wr_i(wr), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .tick_o(tick), .domain_rst_o(drst));

   strobe_divider #(.DIV_W(8), .LOCK_AT_ALT(1'b1), .RST_CYCLES(BENCH_RST)) uut_alt (
      .clk_i(clk), .rst_i(rst), .bus_wr_i(wr), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata_alt), .tick_o(tick_alt), .domain_rst_o(drst_alt));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // drive one write; returns at the falling edge right after the write edge
   task automatic write_reg(input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1;
      wdata = d;
      @(negedge clk);
      wr = 1'b0;
      wdata = '0;
   endtask

   function automatic logic [31:0] ctl(input bit en, input bit rq, input bit ld, input int field);
      return {20'd0, field[7:0], 1'b0, ld, rq, en};
   endfunction

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int ticks;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1 reset state, R11 alternate lock placement
      chk("R1 reset word", rdata, 32'h8000_0010);
      chk("R1 tick", {31'd0, tick}, 32'd0);
      chk("R1 domain reset", {31'd0, drst}, 32'd0);
      chk("R11 alt reset word", rdata_alt, 32'h0800_0010);

      // R3 R4 R6 R7: table walk of loads with enable
      for (int v = 0; v < NVEC; v++) begin
         int n;
         n = VEC_N[v];
         write_reg(ctl(1'b1, 1'b0, 1'b1, VEC_FIELD[v]));
         chk("R11 alt lock drops", {31'd0, rdata_alt[27]}, 32'd0);
         for (int j = 0; j <= 4 * n; j++) begin
            chk((VEC_FIELD[v] == 0) ? "R4 tick" : "R7 tick",
                {31'd0, tick}, {31'd0, (j % n) == n - 1});
            if (j == n - 1 || j == n || j == 0)
               chk("R6 lock", {31'd0, rdata[31]}, {31'd0, j >= n});
            @(negedge clk);
         end
         chk("R3 relocked", {31'd0, rdata[31]}, 32'd1);
      end

      // R5: staged field does not change a running period of 3
      write_reg(ctl(1'b1, 1'b0, 1'b1, 3));
      repeat (6) @(negedge clk);
      write_reg(ctl(1'b1, 1'b0, 1'b0, 7));
      chk("R5 readback", rdata, 32'h8000_0071);
      ticks = 0;
      for (int j = 0; j < 21; j++) begin
         if (tick) ticks++;
         @(negedge clk);
      end
      chk("R5 period kept", ticks, 32'd7);

      // R12 + R8: clear enable, new field and load in one write
      write_reg(ctl(1'b0, 1'b0, 1'b1, 4));
      chk("R12 lock dropped", {31'd0, rdata[31]}, 32'd0);
      ticks = 0;
      for (int j = 0; j < 20; j++) begin
         if (j == 3) chk("R12 lock not yet", {31'd0, rdata[31]}, 32'd0);
         if (j == 4) chk("R12 lock back", {31'd0, rdata[31]}, 32'd1);
         if (tick) ticks++;
         @(negedge clk);
      end
      chk("R8 gated", ticks, 32'd0);
      chk("R12 word", rdata, 32'h8000_0040);

      // R9 + R10: domain reset pulse, self-clearing command bits
      write_reg(ctl(1'b1, 1'b1, 1'b1, 2));
      chk("R10 self-clear", {30'd0, rdata[2:1]}, 32'd0);
      for (int j = 0; j <= BENCH_RST; j++) begin
         if (j == 0 || j == BENCH_RST - 1 || j == BENCH_RST)
            chk("R9 pulse", {31'd0, drst}, {31'd0, j < BENCH_RST});
         @(negedge clk);
      end

      // R2: bits above the field and bit 3 are not stored
      write_reg(32'hFFFF_F0F9 & ~32'h6);
      chk("R2 layout", rdata, 32'h8000_00F1);
      chk("R11 alt layout", rdata_alt, 32'h0800_00F1);

      // R1 again: reset returns everything
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 re-reset word", rdata, 32'h8000_0010);
      chk("R1 re-reset tick", {31'd0, tick}, 32'd0);

      finish_run();
   end
endmodule